// File: doc/BRIEF.md
# Critical-Word-First Cache Line Burst Sequencer

This block turns a single cache-fill request into the four word addresses of one cache line, placed on a word-wide memory port. A line holds four 32-bit words, so it spans 16 bytes. The word the processor asked for is always fetched first. The other three words follow in one of two orders, chosen per request. In wrap-around order, the word index counts upward modulo four. In interleaved order, the word index is the starting index XORed with the beat number.

The requester pulses a start strobe together with the byte address and the order choice, and then only waits. The block latches the request and presents one word address at a time. It moves to the next word only when memory returns ready for the current one. While the final word address is on the port, a last-beat flag is raised. On the cycle in which ready is seen for that final word, a one-cycle line-done pulse is issued. A busy output covers the whole burst. Start strobes that arrive while the block is busy are dropped.

Top module: `burst_line_seq`

## Requirements
- R1: After reset, busy_o, last_o and done_o are 0 and word_addr_o is all zeros.
- R2: A start_i that is sampled high while busy_o is 0 is accepted. From the next cycle, busy_o is 1 and word_addr_o is the requested address with bits 1:0 forced to 0.
- R3: While busy_o is 1, word_addr_o bits 31:4 equal the requested address bits 31:4, and bits 1:0 are 0.
- R4: With order_sel_i = 0 (wrap-around), beat k (k = 0..3) presents the word index (s + k) mod 4 in bits 3:2. Here s is the requested bits 3:2.
- R5: With order_sel_i = 1 (interleaved), beat k presents the word index s XOR k in bits 3:2.
- R6: While busy_o is 1 and mem_rdy_i is 0, word_addr_o and last_o hold their values.
- R7: last_o is 1 exactly while the fourth beat's address is presented.
- R8: done_o is 1 for exactly the cycle in which mem_rdy_i is sampled high on the fourth beat. busy_o is 0 from the next cycle.
- R9: While busy_o is 1, start_i, req_addr_i and order_sel_i have no effect on the address sequence, on last_o or on when the burst ends.
- R10: While busy_o is 0, mem_rdy_i has no effect: word_addr_o stays zero and last_o and done_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a line fill |
| req_addr_i | input | 32 | Byte address of the requested word |
| order_sel_i | input | 1 | 0 selects wrap-around order, 1 selects interleaved order |
| mem_rdy_i | input | 1 | Memory accepted the current word |
| word_addr_o | output | 32 | Current word address, zero while idle |
| last_o | output | 1 | The current beat is the final one of the line |
| done_o | output | 1 | One-cycle pulse when the final beat completes |
| busy_o | output | 1 | A burst is in progress |

## Verification
An accepted start raises busy_o and shows the first address one register stage later. Each beat's address changes one cycle after the cycle in which mem_rdy_i was sampled high. last_o follows the registered beat, so it shares the timing of the address. done_o is combinational on the final beat, so it appears in the same cycle as the ready that ends the burst, and busy_o falls one cycle after that. The bench changes inputs just after a rising edge and samples at the falling edge. Every comparison therefore sees the values that were settled after the edge that caused them.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LINE_WORDS = 4;
    localparam int DEF_BYTE_OFF_W = 2;

endpackage

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_seq_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] start_idx_i,
    input  logic [IDX_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [IDX_W-1:0] word_idx_o
);

    logic [IDX_W-1:0] wrap_idx;
    logic [IDX_W-1:0] xor_idx;

    // The sum wraps because it is truncated to IDX_W bits.
    assign wrap_idx = start_idx_i + beat_i;

    for (genvar b = 0; b < IDX_W; b++) begin : g_xor_bit
        assign xor_idx[b] = start_idx_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_XOR:  word_idx_o = xor_idx;
            default:  word_idx_o = wrap_idx;
        endcase
    end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 2,
    parameter int LINE_OFF_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic                     order_sel_i,
    input  logic                     mem_rdy_i,
    output logic                     busy_o,
    output logic [IDX_W-1:0]         beat_o,
    output logic [IDX_W-1:0]         start_idx_o,
    output order_e                   order_o,
    output logic [ADDR_W-LINE_OFF_W-1:0] line_o,
    output logic                     last_o,
    output logic                     done_o
);

    localparam int               LINE_W    = ADDR_W - LINE_OFF_W;
    localparam logic [IDX_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  beat;
        logic [IDX_W-1:0]  start_idx;
        order_e            order;
        logic [LINE_W-1:0] line;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic     accept_d;
    logic     advance_d;
    logic     final_beat_d;

    logic unused_low_bits;
    assign unused_low_bits = ^req_addr_i[LINE_OFF_W-IDX_W-1:0];

    always_comb begin
        st_d         = st_q;
        final_beat_d = st_q.busy && (st_q.beat == LAST_BEAT);
        accept_d     = start_i && !st_q.busy;
        advance_d    = st_q.busy && mem_rdy_i;

        if (accept_d) begin
            st_d.busy      = 1'b1;
            st_d.beat      = '0;
            st_d.start_idx = req_addr_i[LINE_OFF_W-1:LINE_OFF_W-IDX_W];
            st_d.order     = order_e'(order_sel_i);
            st_d.line      = req_addr_i[ADDR_W-1:LINE_OFF_W];
        end else if (advance_d) begin
            st_d.beat = st_q.beat + 1'b1;
            if (final_beat_d) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign beat_o      = st_q.beat;
    assign start_idx_o = st_q.start_idx;
    assign order_o     = st_q.order;
    assign line_o      = st_q.line;
    assign last_o      = final_beat_d;
    assign done_o      = final_beat_d && mem_rdy_i;

endmodule

// File: rtl/burst_addr_fmt.sv
module burst_addr_fmt #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 2,
    parameter int BYTE_OFF_W = 2
) (
    input  logic                                busy_i,
    input  logic [ADDR_W-IDX_W-BYTE_OFF_W-1:0]  line_i,
    input  logic [IDX_W-1:0]                    word_idx_i,
    output logic [ADDR_W-1:0]                   word_addr_o
);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = {line_i, word_idx_i, {BYTE_OFF_W{1'b0}}};
        word_addr_o = busy_i ? addr_d : '0;
    end

endmodule

// File: rtl/burst_line_seq.sv
module burst_line_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    parameter int BYTE_OFF_W = DEF_BYTE_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              order_sel_i,
    input  logic              mem_rdy_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              last_o,
    output logic              done_o,
    output logic              busy_o
);

    localparam int IDX_W      = $clog2(LINE_WORDS);
    localparam int LINE_OFF_W = IDX_W + BYTE_OFF_W;
    localparam int LINE_W     = ADDR_W - LINE_OFF_W;

    logic [IDX_W-1:0]  beat;
    logic [IDX_W-1:0]  start_idx;
    logic [IDX_W-1:0]  word_idx;
    order_e            order;
    logic [LINE_W-1:0] line;

    burst_ctrl #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .LINE_OFF_W (LINE_OFF_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .req_addr_i  (req_addr_i),
        .order_sel_i (order_sel_i),
        .mem_rdy_i   (mem_rdy_i),
        .busy_o      (busy_o),
        .beat_o      (beat),
        .start_idx_o (start_idx),
        .order_o     (order),
        .line_o      (line),
        .last_o      (last_o),
        .done_o      (done_o)
    );

    burst_order_gen #(
        .IDX_W (IDX_W)
    ) u_order (
        .start_idx_i (start_idx),
        .beat_i      (beat),
        .order_i     (order),
        .word_idx_o  (word_idx)
    );

    burst_addr_fmt #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .BYTE_OFF_W (BYTE_OFF_W)
    ) u_fmt (
        .busy_i      (busy_o),
        .line_i      (line),
        .word_idx_i  (word_idx),
        .word_addr_o (word_addr_o)
    );

endmodule

// File: rtl/burst_line_seq_chk.sv
module burst_line_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 4,
    parameter int BYTE_OFF_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_rdy_i,
    input logic [ADDR_W-1:0] word_addr_o,
    input logic              last_o,
    input logic              done_o,
    input logic              busy_o
);

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_LINE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
        (word_addr_o[ADDR_W-1:LINE_OFF_W] == $past(word_addr_o[ADDR_W-1:LINE_OFF_W]))); // R3

    AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        word_addr_o[BYTE_OFF_W-1:0] == '0); // R3

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_rdy_i) |=> ($stable(word_addr_o) && $stable(last_o))); // R6

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> busy_o); // R7

    AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (last_o && mem_rdy_i)); // R8

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (word_addr_o == '0 && !last_o && !done_o)); // R10

endmodule

bind burst_line_seq burst_line_seq_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_OFF_W (LINE_OFF_W),
    .BYTE_OFF_W (BYTE_OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_rdy_i   (mem_rdy_i),
    .word_addr_o (word_addr_o),
    .last_o      (last_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
);

// File: tb/tb_burst_line_seq.sv
module tb_burst_line_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] addr;
        logic        last;
        logic        mode;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        order_sel_i = 1'b0;
    logic        mem_rdy_i = 1'b0;
    logic [31:0] word_addr_o;
    logic        last_o, done_o, busy_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_line_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .req_addr_i  (req_addr_i),
        .order_sel_i (order_sel_i),
        .mem_rdy_i   (mem_rdy_i),
        .word_addr_o (word_addr_o),
        .last_o      (last_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares every busy cycle against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && busy_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected busy", {31'd0, busy_o}, 32'd0);
            end else begin
                check(word_addr_o == sb[0].addr,
                      sb[0].mode ? "R5 R6 interleaved addr" : "R4 R6 wrap addr",
                      word_addr_o, sb[0].addr);
                check(last_o == sb[0].last, "R7 last flag", {31'd0, last_o}, {31'd0, sb[0].last});
                if (mem_rdy_i) begin
                    check(done_o == sb[0].last, "R8 done pulse", {31'd0, done_o}, {31'd0, sb[0].last});
                    void'(sb.pop_front());
                end else begin
                    check(done_o == 1'b0, "R8 done while waiting", {31'd0, done_o}, 32'd0);
                end
            end
        end
    end

    // Driver: pushes the expected beats and then paces the ready handshake
    task automatic run_burst(input logic [31:0] a, input bit mode, input int gap, input bit junk);
        logic [1:0] s;
        s = a[3:2];
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            logic [1:0] idx;
            idx = mode ? (s ^ 2'(k)) : 2'(s + 2'(k));
            e.addr = {a[31:4], idx, 2'b00};
            e.last = (k == 3);
            e.mode = mode;
            sb.push_back(e);
        end
        @(posedge clk); #1;
        start_i = 1'b1; req_addr_i = a; order_sel_i = mode;
        @(negedge clk);
        check(busy_o == 1'b0, "R2 idle before accept", {31'd0, busy_o}, 32'd0);
        @(posedge clk); #1;
        start_i = 1'b0; req_addr_i = ~a; order_sel_i = ~mode;
        @(negedge clk);
        check(busy_o == 1'b1, "R2 busy after start", {31'd0, busy_o}, 32'd1);
        check(word_addr_o == {a[31:2], 2'b00}, "R2 R3 first word", word_addr_o, {a[31:2], 2'b00});
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < gap; g++) begin
                if (junk) begin
                    start_i = 1'b1; req_addr_i = a ^ 32'h5A5A_0034; order_sel_i = ~mode;
                end
                @(posedge clk); #1;
            end
            start_i = 1'b0;
            mem_rdy_i = 1'b1;
            @(posedge clk); #1;
            mem_rdy_i = 1'b0;
        end
        @(negedge clk);
        check(busy_o == 1'b0, "R8 busy drops after done", {31'd0, busy_o}, 32'd0);
        check(sb.size() == 0, "R9 beat count", sb.size(), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy_o == 1'b0 && last_o == 1'b0 && done_o == 1'b0, "R1 reset flags",
              {29'd0, busy_o, last_o, done_o}, 32'd0);
        check(word_addr_o == '0, "R1 reset addr", word_addr_o, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R10: ready while idle changes nothing
        mem_rdy_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(word_addr_o == '0 && !last_o && !done_o && !busy_o, "R10 idle ready ignored",
              word_addr_o, 32'd0);
        @(posedge clk); #1;
        mem_rdy_i = 1'b0;

        run_burst(32'h0000_0044, 1'b0, 0, 1'b0);   // R4 start 01
        run_burst(32'h1234_5678, 1'b0, 2, 1'b0);   // R4 R6 start 10 with waits
        run_burst(32'hFFFF_FFFF, 1'b0, 1, 1'b0);   // R3 start 11, low bits dropped
        run_burst(32'h0000_0040, 1'b1, 0, 1'b0);   // R5 start 00
        run_burst(32'h8000_0047, 1'b1, 1, 1'b0);   // R5 start 01
        run_burst(32'hABCD_EF08, 1'b1, 3, 1'b1);   // R5 R9 start 10, junk starts
        run_burst(32'h0000_004C, 1'b1, 2, 1'b1);   // R5 R9 start 11
        run_burst(32'h7654_3214, 1'b0, 2, 1'b1);   // R4 R9

        @(negedge clk);
        check(word_addr_o == '0, "R10 idle after bursts", word_addr_o, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule